// File: doc/BRIEF.md
# Sliding-Window Register File

This block is a large physical register file of which a program sees only a small window at any time. Each 5-bit register number from an instruction is added to a window base pointer to form the physical index. Both reads and the single write are relocated in this way. A call event moves the window up by half a window, and a return event moves it back down by the same amount. Consecutive windows therefore share half their registers, and a caller passes arguments to a callee through the shared half.

A call that would push the window past the top of the physical file, or a return that would push it below zero, is refused. The pointer keeps its value and a one-cycle trap pulse is raised, so the core can spill or refill windows.

The default build has 1024 physical registers, a 32-register window and a 16-register step. The pointer therefore takes the values 0, 16, ..., 992.

Top module: `srf_top`

## Requirements
- R1: While reset is applied and after it is released, `base_o` is 0 and `trap_o` is 0 until the first call or return.
- R2: Each read port returns, in the same cycle and with no clock edge, the physical register at `base_o + sel` for its own 5-bit selector.
- R3: When `wr_en_i` is 1, `wr_data_i` is stored at the rising edge into physical register `base_o + wr_sel_i`. The value of `base_o` used is the one held before any call or return taken at that same edge.
- R4: With `call_i`=1, `ret_i`=0 and `base_o` below 992, `base_o` increases by 16 at the edge.
- R5: With `ret_i`=1, `call_i`=0 and `base_o` above 0, `base_o` decreases by 16 at the edge.
- R6: With `call_i`=1, `ret_i`=0 and `base_o`=992, `base_o` keeps its value and `trap_o` is 1 in the following cycle.
- R7: With `ret_i`=1, `call_i`=0 and `base_o`=0, `base_o` keeps its value and `trap_o` is 1 in the following cycle.
- R8: `trap_o` is a one-cycle pulse. It is 1 only in the cycle directly after a refused move, and 0 after any cycle without one.
- R9: When `call_i` and `ret_i` are both 1, `base_o` is unchanged and no trap is raised.
- R10: The windows overlap. After a call, the callee's registers 0..15 are the caller's registers 16..31.
- R11: When `wr_en_i` is 0, no register changes, whatever `wr_sel_i` and `wr_data_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| call_i | input | 1 | Call strobe: move the window up |
| ret_i | input | 1 | Return strobe: move the window down |
| wr_en_i | input | 1 | Write enable |
| wr_sel_i | input | 5 | Window-relative write register number |
| wr_data_i | input | 32 | Write data |
| rd_a_sel_i | input | 5 | Window-relative register number, read port A |
| rd_a_data_o | output | 32 | Read data, port A |
| rd_b_sel_i | input | 5 | Window-relative register number, read port B |
| rd_b_data_o | output | 32 | Read data, port B |
| base_o | output | 10 | Current window base pointer |
| trap_o | output | 1 | One-cycle pulse flagging a refused call or return |

## Verification
The first pattern fills every register of window 0 with a distinct value and reads it back on both ports using different selectors. This separates correct relocation from crossed ports or a dropped offset. Writes combined with a call in the same cycle, followed by reads through the new window, tell whether the write used the old or the new pointer and whether the overlap maps caller 16..31 onto callee 0..15. Long runs of calls to the top and returns to the bottom, with repeated moves at each boundary, separate trapping from wraparound. They also separate a one-cycle trap pulse from a sticky one. Simultaneous call and return, and writes with the enable low, show whether state changes when it must not.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [1:0] {
    MV_HOLD = 2'b00,
    MV_UP   = 2'b01,
    MV_DOWN = 2'b10,
    MV_BOTH = 2'b11
  } move_e;

  function automatic move_e move_decode(input logic up, input logic down);
    move_e m;
    m = move_e'({down, up});
    return m;
  endfunction

endpackage

// File: rtl/srf_rst_sync.sv
module srf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;

endmodule

// File: rtl/srf_ptr_ctrl.sv
module srf_ptr_ctrl #(
  parameter int PHYS_REGS = 1024,
  parameter int WIN_REGS  = 32,
  parameter int STEP      = 16,
  localparam int PTR_W    = $clog2(PHYS_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             call_i,
  input  logic             ret_i,
  output logic [PTR_W-1:0] base_o,
  output logic             trap_o
);
  import srf_pkg::*;

  localparam logic [PTR_W-1:0] TOP_V  = PTR_W'(PHYS_REGS - WIN_REGS);
  localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);
  localparam logic [PTR_W-1:0] ZERO_V = '0;

  logic [PTR_W-1:0] base_q, base_d;
  logic             trap_q, trap_d;
  logic             base_en;
  move_e            mv;

  always_comb begin
    mv      = move_decode(call_i, ret_i);
    base_d  = base_q;
    trap_d  = 1'b0;
    base_en = 1'b0;
    unique case (mv)
      MV_UP: begin
        if (base_q >= TOP_V) begin
          trap_d = 1'b1;
        end else begin
          base_d  = base_q + STEP_V;
          base_en = 1'b1;
        end
      end
      MV_DOWN: begin
        if (base_q == ZERO_V) begin
          trap_d = 1'b1;
        end else begin
          base_d  = base_q - STEP_V;
          base_en = 1'b1;
        end
      end
      default: begin
        base_d  = base_q;
        base_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
    end else begin
      trap_q <= trap_d;
    end
  end

  assign base_o = base_q;
  assign trap_o = trap_q;

endmodule

// File: rtl/srf_addr_map.sv
module srf_addr_map #(
  parameter int PHYS_REGS = 1024,
  parameter int WIN_REGS  = 32,
  localparam int PTR_W    = $clog2(PHYS_REGS),
  localparam int SEL_W    = $clog2(WIN_REGS)
) (
  input  logic [PTR_W-1:0] base_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [PTR_W-1:0] phys_o
);

  always_comb begin
    phys_o = base_i + PTR_W'(sel_i);
  end

endmodule

// File: rtl/srf_storage.sv
module srf_storage #(
  parameter int PHYS_REGS = 1024,
  parameter int DATA_W    = 32,
  parameter int N_RD      = 2,
  localparam int PTR_W    = $clog2(PHYS_REGS)
) (
  input  logic                        clk,
  input  logic                        we_i,
  input  logic [PTR_W-1:0]            waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [N_RD-1:0][PTR_W-1:0]  raddr_i,
  output logic [N_RD-1:0][DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] regs_q [PHYS_REGS];

  always_ff @(posedge clk) begin
    if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    always_comb begin
      rdata_o[p] = regs_q[raddr_i[p]];
    end
  end

endmodule

// File: rtl/srf_top.sv
module srf_top #(
  parameter int PHYS_REGS = 1024,
  parameter int WIN_REGS  = 32,
  parameter int STEP      = 16,
  parameter int DATA_W    = 32,
  localparam int PTR_W    = $clog2(PHYS_REGS),
  localparam int SEL_W    = $clog2(WIN_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_a_sel_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [SEL_W-1:0]  rd_b_sel_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  output logic [PTR_W-1:0]  base_o,
  output logic              trap_o
);

  localparam int N_RD = 2;

  logic                        rst_sync_n;
  logic [PTR_W-1:0]            base;
  logic [PTR_W-1:0]            wr_phys;
  logic [N_RD-1:0][SEL_W-1:0]  rd_sel;
  logic [N_RD-1:0][PTR_W-1:0]  rd_phys;
  logic [N_RD-1:0][DATA_W-1:0] rd_data;

  srf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  srf_ptr_ctrl #(
    .PHYS_REGS (PHYS_REGS),
    .WIN_REGS  (WIN_REGS),
    .STEP      (STEP)
  ) u_ptr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .call_i (call_i),
    .ret_i  (ret_i),
    .base_o (base),
    .trap_o (trap_o)
  );

  srf_addr_map #(
    .PHYS_REGS (PHYS_REGS),
    .WIN_REGS  (WIN_REGS)
  ) u_wmap (
    .base_i (base),
    .sel_i  (wr_sel_i),
    .phys_o (wr_phys)
  );

  assign rd_sel[0] = rd_a_sel_i;
  assign rd_sel[1] = rd_b_sel_i;

  for (genvar p = 0; p < N_RD; p++) begin : g_rmap
    srf_addr_map #(
      .PHYS_REGS (PHYS_REGS),
      .WIN_REGS  (WIN_REGS)
    ) u_rmap (
      .base_i (base),
      .sel_i  (rd_sel[p]),
      .phys_o (rd_phys[p])
    );
  end

  srf_storage #(
    .PHYS_REGS (PHYS_REGS),
    .DATA_W    (DATA_W),
    .N_RD      (N_RD)
  ) u_store (
    .clk     (clk),
    .we_i    (wr_en_i),
    .waddr_i (wr_phys),
    .wdata_i (wr_data_i),
    .raddr_i (rd_phys),
    .rdata_o (rd_data)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign base_o      = base;

endmodule

// File: rtl/srf_chk.sv
module srf_chk #(
  parameter int PHYS_REGS = 1024,
  parameter int WIN_REGS  = 32,
  parameter int STEP      = 16,
  localparam int PTR_W    = $clog2(PHYS_REGS)
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             call_i,
  input logic             ret_i,
  input logic [PTR_W-1:0] base_o,
  input logic             trap_o
);

  localparam logic [PTR_W-1:0] TOP_V = PTR_W'(PHYS_REGS - WIN_REGS);
  localparam logic [PTR_W-1:0] STP_V = PTR_W'(STEP);

  logic up_ok, dn_ok, up_bad, dn_bad;
  assign up_ok  = call_i && !ret_i && (base_o != TOP_V);
  assign dn_ok  = ret_i && !call_i && (base_o != '0);
  assign up_bad = call_i && !ret_i && (base_o == TOP_V);
  assign dn_bad = ret_i && !call_i && (base_o == '0);

  AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    up_ok |=> base_o == $past(base_o) + STP_V); // R4
  AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dn_ok |=> base_o == $past(base_o) - STP_V); // R5
  AST_CALL_TRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    up_bad |=> trap_o && $stable(base_o)); // R6
  AST_RET_TRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dn_bad |=> trap_o && $stable(base_o)); // R7
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(up_bad || dn_bad) |=> !trap_o); // R8
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (call_i && ret_i) |=> $stable(base_o) && !trap_o); // R9
  AST_BASE_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    base_o <= TOP_V); // R4

endmodule

bind srf_top srf_chk #(
  .PHYS_REGS (PHYS_REGS),
  .WIN_REGS  (WIN_REGS),
  .STEP      (STEP)
) u_srf_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .base_o     (base_o),
  .trap_o     (trap_o)
);

// File: tb/test_srf_top.sv
`timescale 1ns/1ps
module test_srf_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        call_i, ret_i, wr_en_i;
  logic [4:0]  wr_sel_i, rd_a_sel_i, rd_b_sel_i;
  logic [31:0] wr_data_i, rd_a_data_o, rd_b_data_o;
  logic [9:0]  base_o;
  logic        trap_o;

  always #2.5 clk = ~clk;

  srf_top i_srf_top (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_a_sel_i(rd_a_sel_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_sel_i(rd_b_sel_i), .rd_b_data_o(rd_b_data_o),
    .base_o(base_o), .trap_o(trap_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] m_mem [1024];
  bit          m_val [1024];
  int          m_base = 0;
  bit          m_trap = 0;
  string       prev_tag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit c, bit r, bit we, logic [4:0] ws,
                      logic [31:0] wd, logic [4:0] ra, logic [4:0] rb);
    @(negedge clk);
    call_i = c; ret_i = r; wr_en_i = we;
    wr_sel_i = ws; wr_data_i = wd; rd_a_sel_i = ra; rd_b_sel_i = rb;
    #1;
    chk(prev_tag, "base", 32'(base_o), 32'(m_base));
    chk(prev_tag, "trap", 32'(trap_o), 32'(m_trap));
    if (m_val[m_base + int'(ra)]) chk(tag, "rdA", rd_a_data_o, m_mem[m_base + int'(ra)]);
    if (m_val[m_base + int'(rb)]) chk(tag, "rdB", rd_b_data_o, m_mem[m_base + int'(rb)]);
    @(posedge clk);
    if (we) begin
      m_mem[m_base + int'(ws)] = wd;
      m_val[m_base + int'(ws)] = 1'b1;
    end
    m_trap = 1'b0;
    if (c && !r) begin
      if (m_base == 992) m_trap = 1'b1; else m_base += 16;
    end else if (r && !c) begin
      if (m_base == 0) m_trap = 1'b1; else m_base -= 16;
    end
    prev_tag = tag;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) m_val[i] = 1'b0;
    rst_n = 1'b0; call_i = 0; ret_i = 0; wr_en_i = 0;
    wr_sel_i = 0; wr_data_i = 0; rd_a_sel_i = 0; rd_b_sel_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "base in reset", 32'(base_o), 32'd0);
    chk("R1", "trap in reset", 32'(trap_o), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R2/R3: fill window 0, read back on both ports
    for (int i = 0; i < 32; i++)
      step("R3", 0, 0, 1, 5'(i), 32'hA500_0000 + 32'(i * 7), 5'(31 - i), 5'(i));
    for (int i = 0; i < 32; i++)
      step("R2", 0, 0, 0, 0, 0, 5'(i), 5'((i + 9) % 32));
    // R11: disabled write leaves register 5 unchanged
    step("R11", 0, 0, 0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd5);
    step("R11", 0, 0, 0, 0, 0, 5'd5, 5'd5);
    // R3 + R10: write caller reg 20 together with a call; callee reg 4 sees it
    step("R3", 1, 0, 1, 5'd20, 32'h1234_5678, 5'd20, 5'd0);
    step("R10", 0, 0, 0, 0, 0, 5'd4, 5'd15);
    step("R10", 0, 0, 1, 5'd2, 32'h0BAD_F00D, 5'd4, 5'd0);
    step("R5", 1'b0, 1'b1, 0, 0, 0, 5'd0, 5'd0);
    step("R10", 0, 0, 0, 0, 0, 5'd18, 5'd20);
    // R9: simultaneous call and return
    step("R9", 1, 1, 0, 0, 0, 5'd1, 5'd2);
    step("R9", 0, 0, 0, 0, 0, 5'd1, 5'd2);
    // R7: return at bottom traps, then R8 pulse ends
    step("R7", 0, 1, 0, 0, 0, 5'd3, 5'd4);
    step("R8", 0, 0, 0, 0, 0, 5'd3, 5'd4);
    // R4: climb to the top, writing the top register of each window
    for (int i = 0; i < 62; i++)
      step("R4", 1, 0, 1, 5'd31, 32'hC000_0000 + 32'(i), 5'd15, 5'd31);
    step("R4", 0, 0, 1, 5'd31, 32'hFFFF_0001, 5'd31, 5'd15);
    // R6: call at top traps twice in a row, then pulse ends (R8)
    step("R6", 1, 0, 0, 0, 0, 5'd31, 5'd0);
    step("R6", 1, 0, 0, 0, 0, 5'd31, 5'd0);
    step("R8", 0, 0, 0, 0, 0, 5'd31, 5'd0);
    step("R9", 1, 1, 0, 0, 0, 5'd31, 5'd16);
    // R5: walk back down reading overlap values
    for (int i = 0; i < 62; i++)
      step("R5", 0, 1, 0, 0, 0, 5'd31, 5'd15);
    step("R7", 0, 1, 0, 0, 0, 5'd20, 5'd0);
    step("R8", 0, 0, 0, 0, 0, 5'd20, 5'd0);
    step("R2", 0, 0, 0, 0, 0, 5'd0, 5'd31);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule